// File: doc/BRIEF.md
# Wired-Output Interrupt Aggregator

This block gathers 32 interrupt lines into one wired interrupt toward a parent controller. Each line owns one bit in a pending register. The bit is captured from the line, and it can also be raised by software. Pending bits whose enable is open are ORed into a single output. Software reaches four registers through a small memory-mapped bus with a combinational read path: pending, software-raise, disable and control.

A single control bit sets the sensing mode for all sources together. In level mode, a line that is high refreshes its pending bit on every clock, so an acknowledge lasts only once the line has dropped. In rising-edge mode, a one-cycle-delayed copy of each line detects a 0-to-1 change, and the captured bit stays set until software clears it. An acknowledge is a write of zeros to the pending register: every bit written as 0 is cleared and every bit written as 1 is kept. A second control bit holds an output-message enable. It is only stored and read back.

Top module: `irq_wire_agg`

## Requirements
- R1: After reset the pending register reads 0, the disable register reads 0xFFFFFFFF, control reads 0 and `irq_out` is low.
- R2: `irq_out` is high exactly when some pending bit is set whose disable bit (offset 0x10) is 0. A disable bit of 1 blocks its source from the output but leaves its pending bit readable.
- R3: With control bit 3 = 0 (level mode), an input that is high at a rising clock edge sets its pending bit at that edge. A clear of that bit has no lasting effect while the input stays high.
- R4: With control bit 3 = 1 (edge mode), a pending bit is set only by a 0-to-1 change of its input between two consecutive clock edges. A line held high does not set the bit again after it has been cleared.
- R5: Writing to offset 0x00 clears every pending bit written as 0 and keeps every bit written as 1. Pending bits are never cleared otherwise.
- R6: Writing to offset 0x08 sets every pending bit written as 1. Bits written as 0 are unaffected.
- R7: When a hardware capture and a clear hit the same bit at the same edge, the bit ends up set.
- R8: Control at offset 0x28 stores bit 3 (edge mode) and bit 5 (message-output mask). Both read back in place. All other control bits read 0.
- R9: Reads of an offset other than 0x00, 0x08, 0x10 and 0x28 return 0. Writes to such offsets change no register.
- R10: The disable register at offset 0x10 is written whole and reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt source lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| irq_out | output | 1 | Wired interrupt to the parent controller |

## Verification
Several kinds of input are applied. Sparse random lines in both sensing modes separate level refresh from edge capture, because a held line behaves differently in the two modes. Random disable patterns, including all-open and all-closed, show whether the output really obeys the enable or just follows the pending bits. Directed sequences place a clear in the same cycle as a capture, and apply a clear to a line still held high, to test the priority and the level refresh. Writes and reads at unmapped offsets show that nothing outside the map is decoded.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned OFS_PEND  = 32'h00;
    localparam int unsigned OFS_RAISE = 32'h08;
    localparam int unsigned OFS_DIS   = 32'h10;
    localparam int unsigned OFS_CTRL  = 32'h28;
    localparam int unsigned CTRL_EDGE_BIT = 3;
    localparam int unsigned CTRL_MSG_BIT  = 5;
    localparam int unsigned NREG = 4;

    typedef enum logic [1:0] {
        SEL_PEND  = 2'd0,
        SEL_RAISE = 2'd1,
        SEL_DIS   = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic            sel,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    output logic [NREG-1:0] hit,
    output logic [NREG-1:0] wstb
);
    localparam logic [AW-1:0] A_PEND  = AW'(OFS_PEND);
    localparam logic [AW-1:0] A_RAISE = AW'(OFS_RAISE);
    localparam logic [AW-1:0] A_DIS   = AW'(OFS_DIS);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);

    always_comb begin
        hit = '0;
        hit[SEL_PEND]  = (addr == A_PEND);
        hit[SEL_RAISE] = (addr == A_RAISE);
        hit[SEL_DIS]   = (addr == A_DIS);
        hit[SEL_CTRL]  = (addr == A_CTRL);
        wstb = (sel && wr) ? hit : '0;
    end
endmodule

// File: rtl/irq_agg_sense.sv
module irq_agg_sense #(
    parameter int NSRC = 32
) (
    input  logic [NSRC-1:0] line,
    input  logic [NSRC-1:0] line_prev,
    input  logic            edge_mode,
    output logic [NSRC-1:0] capture
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign capture[i] = edge_mode ? (line[i] & ~line_prev[i]) : line[i];
    end
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic [NREG-1:0] hit,
    input  logic            rd_en,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] dis,
    input  logic            edge_mode,
    input  logic            msg_mask,
    output logic [NSRC-1:0] rdata
);
    logic [NSRC-1:0] ctrl_word;

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_EDGE_BIT] = edge_mode;
        ctrl_word[CTRL_MSG_BIT]  = msg_mask;
        rdata = '0;
        if (rd_en) begin
            if (hit[SEL_PEND])      rdata = pend;
            else if (hit[SEL_DIS])  rdata = dis;
            else if (hit[SEL_CTRL]) rdata = ctrl_word;
        end
    end
endmodule

// File: rtl/irq_wire_agg.sv
module irq_wire_agg
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_out
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] dis;
        logic [NSRC-1:0] line_prev;
        logic            edge_mode;
        logic            msg_mask;
    } state_t;

    state_t st_d, st_q;
    logic [NREG-1:0] hit, wstb;
    logic [NSRC-1:0] capture;
    logic [NSRC-1:0] pend_vis, dis_vis;
    logic            edge_vis;

    irq_agg_decode #(.AW(AW)) u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .hit  (hit),
        .wstb (wstb)
    );

    irq_agg_sense #(.NSRC(NSRC)) u_sense (
        .line      (irq_in),
        .line_prev (st_q.line_prev),
        .edge_mode (st_q.edge_mode),
        .capture   (capture)
    );

    irq_agg_rdmux #(.NSRC(NSRC)) u_rdmux (
        .hit       (hit),
        .rd_en     (bus_sel && !bus_wr),
        .pend      (st_q.pend),
        .dis       (st_q.dis),
        .edge_mode (st_q.edge_mode),
        .msg_mask  (st_q.msg_mask),
        .rdata     (bus_rdata)
    );

    always_comb begin
        logic [NSRC-1:0] keep;
        logic [NSRC-1:0] raise;
        st_d = st_q;
        keep  = wstb[SEL_PEND]  ? bus_wdata : '1;
        raise = wstb[SEL_RAISE] ? bus_wdata : '0;
        // captures and software raises are ORed after the clear: set wins
        st_d.pend      = (st_q.pend & keep) | raise | capture;
        st_d.line_prev = irq_in;
        if (wstb[SEL_DIS]) begin
            st_d.dis = bus_wdata;
        end
        if (wstb[SEL_CTRL]) begin
            st_d.edge_mode = bus_wdata[CTRL_EDGE_BIT];
            st_d.msg_mask  = bus_wdata[CTRL_MSG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend      <= '0;
            st_q.dis       <= '1;
            st_q.line_prev <= '0;
            st_q.edge_mode <= 1'b0;
            st_q.msg_mask  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out  = |(st_q.pend & ~st_q.dis);
    assign pend_vis = st_q.pend;
    assign dis_vis  = st_q.dis;
    assign edge_vis = st_q.edge_mode;
endmodule

// File: rtl/irq_wire_agg_chk.sv
module irq_wire_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int AW   = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_in,
    input logic            bus_sel,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [NSRC-1:0] bus_wdata,
    input logic [NSRC-1:0] bus_rdata,
    input logic            irq_out,
    input logic [NSRC-1:0] pend_vis,
    input logic [NSRC-1:0] dis_vis,
    input logic            edge_vis
);
    logic wr_pend, wr_raise, unmapped;
    assign wr_pend  = bus_sel && bus_wr && (bus_addr == AW'(OFS_PEND));
    assign wr_raise = bus_sel && bus_wr && (bus_addr == AW'(OFS_RAISE));
    assign unmapped = (bus_addr != AW'(OFS_PEND)) && (bus_addr != AW'(OFS_RAISE))
                   && (bus_addr != AW'(OFS_DIS))  && (bus_addr != AW'(OFS_CTRL));

    // R5: pending bits only fall on an explicit clear write
    a_r5_sticky_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> ((pend_vis & $past(pend_vis)) == $past(pend_vis)));

    // R3 and R7: in level mode a high line is pending at the next edge, even under a clear
    a_r3_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_vis |=> ((pend_vis & $past(irq_in)) == $past(irq_in)));

    // R6: software raise sets the written ones
    a_r6_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wr_raise |=> ((pend_vis & $past(bus_wdata)) == $past(bus_wdata)));

    // R2: a fully closed disable register silences the output
    a_r2_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_vis == '1) |-> !irq_out);

    // R9: unmapped reads return zero
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && unmapped) |-> (bus_rdata == '0));
endmodule

bind irq_wire_agg irq_wire_agg_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend_vis  (pend_vis),
    .dis_vis   (dis_vis),
    .edge_vis  (edge_vis)
);

// File: tb/irq_wire_agg_test.sv
`timescale 1ns/100ps
module irq_wire_agg_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;

    always #4 clk = ~clk;

    irq_wire_agg uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // reference state
    logic [31:0] m_pend, m_dis, m_prev;
    logic        m_edge, m_msg;
    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    function automatic logic [31:0] next_pend(logic [31:0] pend, prev, line,
                                              logic edge_m, logic wr, logic [7:0] a,
                                              logic [31:0] wd);
        logic [31:0] cap, keep, raise;
        cap   = edge_m ? (line & ~prev) : line;
        keep  = (wr && a == 8'h00) ? wd : 32'hFFFF_FFFF;
        raise = (wr && a == 8'h08) ? wd : 32'h0;
        return (pend & keep) | raise | cap;
    endfunction

    function automatic logic [31:0] ctrl_word(logic e, logic m);
        logic [31:0] w;
        w = '0;
        w[3] = e;
        w[5] = m;
        return w;
    endfunction

    function automatic logic [31:0] reg_value(logic [7:0] a);
        case (a)
            8'h00:   return m_pend;
            8'h10:   return m_dis;
            8'h28:   return ctrl_word(m_edge, m_msg);
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one clock: drive at falling edge, check the output just after the rising edge
    task automatic step(logic [31:0] line, logic wr, logic [7:0] a, logic [31:0] wd);
        logic [31:0] np;
        @(negedge clk);
        irq_in = line; bus_sel = wr; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        np = next_pend(m_pend, m_prev, line, m_edge, wr, a, wd);
        if (wr && a == 8'h10) m_dis = wd;
        if (wr && a == 8'h28) begin m_edge = wd[3]; m_msg = wd[5]; end
        m_pend = np;
        m_prev = line;
        @(posedge clk);
        #1;
        chk("R2 irq_out", {31'b0, irq_out}, {31'b0, |(m_pend & ~m_dis)});
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // combinational read between the rising and the next falling edge
    task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        chk(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; irq_in = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        m_pend = '0; m_dis = '1; m_prev = '0; m_edge = 0; m_msg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        rd("R1 pending", 8'h00, 32'h0);
        rd("R1 disable", 8'h10, 32'hFFFF_FFFF);
        rd("R1 control", 8'h28, 32'h0);
        rd("R9 unmapped read", 8'h04, 32'h0);

        // level mode, open all enables
        step(32'h0, 1, 8'h10, 32'h0);
        rd("R10 disable readback", 8'h10, 32'h0);
        step(32'h1, 0, 8'h00, 32'h0);
        rd("R3 level capture", 8'h00, 32'h1);
        chk("R3 irq_out high", {31'b0, irq_out}, 32'h1);
        step(32'h1, 1, 8'h00, 32'h0);
        rd("R3 clear while high has no lasting effect", 8'h00, 32'h1);
        step(32'h0, 1, 8'h00, 32'h0);
        rd("R5 clear after line drop", 8'h00, 32'h0);
        step(32'h0, 0, 8'h00, 32'h0);
        rd("R5 stays clear", 8'h00, 32'h0);

        // software raise and partial acknowledge
        step(32'h0, 1, 8'h08, 32'h8000_0010);
        rd("R6 raise sets ones", 8'h00, 32'h8000_0010);
        step(32'h0, 1, 8'h08, 32'h0);
        rd("R6 zeros have no effect", 8'h00, 32'h8000_0010);
        step(32'h0, 1, 8'h00, 32'h0000_0010);
        rd("R5 ones written are kept", 8'h00, 32'h0000_0010);

        // disable gating
        step(32'h0, 1, 8'h10, 32'h0000_0010);
        chk("R2 disabled source quiet", {31'b0, irq_out}, 32'h0);
        rd("R2 pending still visible", 8'h00, 32'h0000_0010);
        step(32'h0, 1, 8'h10, 32'hFFFF_FFEF);
        chk("R2 enabled source drives", {31'b0, irq_out}, 32'h1);
        step(32'h0, 1, 8'h00, 32'h0);

        // control register
        step(32'h0, 1, 8'h28, 32'hFFFF_FFFF);
        rd("R8 control keeps bits 3 and 5", 8'h28, 32'h0000_0028);
        step(32'h0, 1, 8'h28, 32'h0000_0008);
        rd("R8 edge only", 8'h28, 32'h0000_0008);

        // edge mode
        step(32'h0, 1, 8'h10, 32'h0);
        step(32'h10, 0, 8'h00, 32'h0);
        rd("R4 rising capture", 8'h00, 32'h10);
        step(32'h10, 1, 8'h00, 32'h0);
        rd("R4 held line not recaptured", 8'h00, 32'h0);
        step(32'h10, 0, 8'h00, 32'h0);
        rd("R4 still clear while held", 8'h00, 32'h0);
        step(32'h0, 0, 8'h00, 32'h0);
        step(32'h10, 1, 8'h00, 32'h0);
        rd("R7 capture beats clear", 8'h00, 32'h10);

        // unmapped write
        step(32'h0, 1, 8'h04, 32'hFFFF_FFFF);
        step(32'h0, 1, 8'h30, 32'hFFFF_FFFF);
        rd("R9 pending unchanged", 8'h00, 32'h10);
        rd("R9 disable unchanged", 8'h10, 32'h0);
        rd("R9 control unchanged", 8'h28, 32'h8);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] line, wd;
            logic        wr;
            logic [7:0]  a;
            int          pick;
            line = $urandom & $urandom & $urandom;
            wr   = ($urandom_range(0, 3) == 0);
            pick = $urandom_range(0, 7);
            case (pick)
                0, 1: a = 8'h00;
                2:    a = 8'h08;
                3, 4: a = 8'h10;
                5:    a = 8'h28;
                6:    a = 8'h04;
                default: a = 8'h2C;
            endcase
            case ($urandom_range(0, 3))
                0: wd = 32'h0;
                1: wd = 32'hFFFF_FFFF;
                default: wd = $urandom;
            endcase
            step(line, wr, a, wd);
            rd("R3/R4/R5 random pending", 8'h00, m_pend);
            if ((n % 16) == 0) rd("R8/R10 random readback", a, reg_value(a));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule